// File: doc/BRIEF.md
# Wake-up power control sequencer

This block follows whether the chip is running from its main supply, from its backup battery, or from nothing at all, and decides when a wake interrupt and a shutdown interrupt may be raised. It runs on the 32.768 kHz timekeeping clock. The supply-good flags come from analog comparators and are synchronised inside the block. The time-match and ring-event strobes come from the alarm comparator and the ring detector, which are separate blocks in the same clock domain.

When the main supply comes back after a stretch on battery, the block waits a fixed holdoff before it accepts ring events or releases wake pulses. A time match seen on battery or during the holdoff is latched and produces one wake pulse when the holdoff ends. The two enable bits survive a system reset and are cleared only when the block leaves the state where both supplies are absent.

Top module: `wkseq_top`

## Requirements
- R1: While `por_n` is low the block shows `pwr_state_o` = 2'b00 (no power), `ring_mask_o` = 1, and `wake_o` and `off_o` = 0.
- R2: With the battery flag high and the main flag low, `pwr_state_o` settles to 2'b01 (battery) and `ring_mask_o` is 1.
- R3: When the main flag returns, `pwr_state_o` reads 2'b10 (holdoff) for exactly HOLD_CYCLES clock cycles, then 2'b11 (main ready). `ring_mask_o` stays 1 until the state reaches 2'b11.
- R4: In main-ready state, a one-cycle `time_hit_i` produces a one-cycle `wake_o` on the next cycle only when the stored time enable is 1.
- R5: In main-ready state, a one-cycle `ring_hit_i` produces a one-cycle `wake_o` on the next cycle only when the stored ring enable is 1.
- R6: A ring event during battery or holdoff state has no effect, and no wake follows the holdoff.
- R7: A time match that is enabled and occurs on battery is remembered. `wake_o` stays 0 throughout the holdoff, is 0 in the first main-ready cycle, and is 1 for exactly one cycle after that.
- R8: A software-off strobe discards a latched wake event, so no wake follows the holdoff.
- R9: `sw_off_i` produces a one-cycle `off_o` on the next cycle when the main supply is present (state 2'b10 or 2'b11). On battery it produces no pulse.
- R10: The enables written through `cfg_we_i` are not changed by `sys_rst_n`.
- R11: With both flags low the state becomes 2'b00. Both enables are cleared and must be written again before events wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| por_n | input | 1 | First-power reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, clears only the output pulses |
| main_ok_i | input | 1 | Main supply good (asynchronous) |
| bat_ok_i | input | 1 | Battery supply good (asynchronous) |
| time_hit_i | input | 1 | Alarm time-match strobe |
| ring_hit_i | input | 1 | Ring event strobe |
| cfg_we_i | input | 1 | Load the two enable bits |
| cfg_time_en_i | input | 1 | Time-match wake enable value |
| cfg_ring_en_i | input | 1 | Ring wake enable value |
| sw_off_i | input | 1 | Software-off command strobe |
| wake_o | output | 1 | Wake interrupt pulse |
| off_o | output | 1 | Off interrupt pulse |
| ring_mask_o | output | 1 | High while the ring input is masked |
| pwr_state_o | output | 2 | 00 none, 01 battery, 10 holdoff, 11 main ready |

## Verification
A holdoff counter that is off by one shows on `pwr_state_o` as a holdoff that is one cycle too long or too short, seen on the first return to main power. A lost or stuck pending latch shows one cycle after the holdoff ends, as a missing wake pulse or as an extra one. Enable bits that are cleared by the wrong reset show as a missing or extra wake pulse on the next time match or ring event.

// File: rtl/wkseq_pkg.sv
package wkseq_pkg;
   typedef enum logic [1:0] {
      PS_NONE = 2'b00,
      PS_BATT = 2'b01,
      PS_HOLD = 2'b10,
      PS_MAIN = 2'b11
   } pstate_e;
endpackage

// File: rtl/wkseq_sync.sv
module wkseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkseq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wkseq_power.sv
module wkseq_power
   import wkseq_pkg::*;
#(
   parameter int HOLD_CYCLES = 32768
) (
   input  logic    clk,
   input  logic    por_n,
   input  logic    main_s,
   input  logic    bat_s,
   output pstate_e state_o
);
   localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("wkseq_power: HOLD_CYCLES must be at least 2");
      end
   endgenerate

   pstate_e        st, st_d;
   logic [CW-1:0]  cnt, cnt_d;

   always_comb begin
      st_d  = st;
      cnt_d = cnt;
      if (!main_s && !bat_s) begin
         st_d  = PS_NONE;
         cnt_d = '0;
      end else if (!main_s) begin
         st_d  = PS_BATT;
         cnt_d = '0;
      end else begin
         unique case (st)
            PS_NONE, PS_BATT: begin
               st_d  = PS_HOLD;
               cnt_d = '0;
            end
            PS_HOLD: begin
               if (cnt == LAST) begin
                  st_d  = PS_MAIN;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt + 1'b1;
               end
            end
            default: st_d = PS_MAIN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
         st  <= PS_NONE;
         cnt <= '0;
      end else begin
         st  <= st_d;
         cnt <= cnt_d;
      end

   assign state_o = st;
endmodule

// File: rtl/wkseq_events.sv
module wkseq_events
   import wkseq_pkg::*;
(
   input  logic    clk,
   input  logic    por_n,
   input  logic    sys_rst_n,
   input  pstate_e state,
   input  logic    cfg_we,
   input  logic    cfg_time_en,
   input  logic    cfg_ring_en,
   input  logic    time_hit,
   input  logic    ring_hit,
   input  logic    sw_off,
   output logic    wake,
   output logic    off
);
   logic time_en, ring_en, pend;
   logic evt, ready, fire, main_up;

   assign ready   = (state == PS_MAIN);
   assign main_up = (state == PS_MAIN) || (state == PS_HOLD);
   assign evt     = (time_hit && time_en) || (ring_hit && ring_en && ready);
   assign fire    = ready && (pend || evt) && !sw_off;

   // enable bits: only first power or the no-supply state clears them
   always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
         time_en <= 1'b0;
         ring_en <= 1'b0;
      end else if (state == PS_NONE) begin
         time_en <= 1'b0;
         ring_en <= 1'b0;
      end else if (cfg_we) begin
         time_en <= cfg_time_en;
         ring_en <= cfg_ring_en;
      end

   always_ff @(posedge clk or negedge por_n)
      if (!por_n)                            pend <= 1'b0;
      else if (state == PS_NONE || sw_off)   pend <= 1'b0;
      else if (fire)                         pend <= 1'b0;
      else                                   pend <= pend || evt;

   always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
         wake <= 1'b0;
         off  <= 1'b0;
      end else if (!sys_rst_n) begin
         wake <= 1'b0;
         off  <= 1'b0;
      end else begin
         wake <= fire;
         off  <= sw_off && main_up;
      end
endmodule

// File: rtl/wkseq_top.sv
module wkseq_top
   import wkseq_pkg::*;
#(
   parameter int HOLD_CYCLES = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst_n,
   input  logic       main_ok_i,
   input  logic       bat_ok_i,
   input  logic       time_hit_i,
   input  logic       ring_hit_i,
   input  logic       cfg_we_i,
   input  logic       cfg_time_en_i,
   input  logic       cfg_ring_en_i,
   input  logic       sw_off_i,
   output logic       wake_o,
   output logic       off_o,
   output logic       ring_mask_o,
   output logic [1:0] pwr_state_o
);
   logic    main_s, bat_s;
   pstate_e state;

   wkseq_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
      .clk(clk), .rst_n(por_n), .d(main_ok_i), .q(main_s));
   wkseq_sync #(.STAGES(SYNC_STAGES)) u_sync_bat (
      .clk(clk), .rst_n(por_n), .d(bat_ok_i), .q(bat_s));

   wkseq_power #(.HOLD_CYCLES(HOLD_CYCLES)) u_power (
      .clk(clk), .por_n(por_n), .main_s(main_s), .bat_s(bat_s),
      .state_o(state));

   wkseq_events u_events (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .state(state),
      .cfg_we(cfg_we_i), .cfg_time_en(cfg_time_en_i),
      .cfg_ring_en(cfg_ring_en_i), .time_hit(time_hit_i),
      .ring_hit(ring_hit_i), .sw_off(sw_off_i),
      .wake(wake_o), .off(off_o));

   assign ring_mask_o = (state != PS_MAIN);
   assign pwr_state_o = state;
endmodule

// File: rtl/wkseq_chk.sv
module wkseq_chk (
   input logic       clk,
   input logic       por_n,
   input logic       sw_off_i,
   input logic       wake_o,
   input logic       off_o,
   input logic       ring_mask_o,
   input logic [1:0] pwr_state_o
);
   // R3
   holdoff_not_skipped_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state_o == 2'b11) |-> ($past(pwr_state_o) == 2'b10 || $past(pwr_state_o) == 2'b11));
   // R7
   wake_only_when_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
      wake_o |-> ($past(pwr_state_o) == 2'b11 && !ring_mask_o));
   // R9
   off_needs_cmd_chk: assert property (@(posedge clk) disable iff (!por_n)
      off_o |-> ($past(sw_off_i) && $past(pwr_state_o[1]) && !wake_o));
   // R8
   off_blocks_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
      wake_o |-> !$past(sw_off_i));
   // R2
   battery_masked_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state_o == 2'b01) |-> ring_mask_o);
   // R11
   nopower_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state_o == 2'b00) |=> (!wake_o && !off_o));
endmodule

bind wkseq_top wkseq_chk u_chk (
   .clk(clk), .por_n(por_n), .sw_off_i(sw_off_i), .wake_o(wake_o),
   .off_o(off_o), .ring_mask_o(ring_mask_o), .pwr_state_o(pwr_state_o));

// File: tb/wkseq_top_test.sv
module wkseq_top_test;
   localparam int H = 64;

   logic clk = 1'b0;
   logic por_n, sys_rst_n, main_ok, bat_ok, time_hit, ring_hit;
   logic cfg_we, cfg_t, cfg_r, sw_off;
   logic wake, off, mask;
   logic [1:0] st;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   wkseq_top #(.HOLD_CYCLES(H)) uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .main_ok_i(main_ok),
      .bat_ok_i(bat_ok), .time_hit_i(time_hit), .ring_hit_i(ring_hit),
      .cfg_we_i(cfg_we), .cfg_time_en_i(cfg_t), .cfg_ring_en_i(cfg_r),
      .sw_off_i(sw_off), .wake_o(wake), .off_o(off), .ring_mask_o(mask),
      .pwr_state_o(st));

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic t, input logic r);
      cfg_we = 1'b1; cfg_t = t; cfg_r = r;
      tick(1);
      cfg_we = 1'b0;
   endtask

   // kind 0: time match, 1: ring event, 2: software off
   task automatic strobe(input int kind);
      if (kind == 0) time_hit = 1'b1;
      else if (kind == 1) ring_hit = 1'b1;
      else sw_off = 1'b1;
      tick(1);
      time_hit = 1'b0; ring_hit = 1'b0; sw_off = 1'b0;
   endtask

   // raise main supply, measure holdoff length and wakes seen in it
   task automatic go_main(output int hold, output int wakes, output int unmask);
      hold = 0; wakes = 0; unmask = 0;
      main_ok = 1'b1;
      for (int i = 0; i < 1000 && st != 2'b11; i++) begin
         tick(1);
         if (st == 2'b10) begin
            hold++;
            if (wake) wakes++;
            if (!mask) unmask++;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hold, wakes, unm;
      por_n = 0; sys_rst_n = 0; main_ok = 0; bat_ok = 0; time_hit = 0;
      ring_hit = 0; cfg_we = 0; cfg_t = 0; cfg_r = 0; sw_off = 0;
      tick(3);
      // R1 reset state
      chk("R1 state", st, 0);
      chk("R1 mask", mask, 1);
      chk("R1 wake", wake, 0);
      chk("R1 off", off, 0);
      por_n = 1; sys_rst_n = 1;
      tick(1);
      bat_ok = 1;
      tick(4);
      chk("R2 state", st, 1);
      chk("R2 mask", mask, 1);
      go_main(hold, wakes, unm);
      chk("R3 holdoff length", hold, H);
      chk("R3 mask in holdoff", unm, 0);
      tick(1);
      chk("R3 ready", st, 3);
      chk("R3 unmasked", mask, 0);

      // R4 R5 sweep over enables and event kinds
      for (int t = 0; t < 2; t++)
         for (int r = 0; r < 2; r++)
            for (int k = 0; k < 2; k++) begin
               cfg(t[0], r[0]);
               strobe(k);
               chk(k == 0 ? "R4 time wake" : "R5 ring wake", wake, k == 0 ? t : r);
               tick(1);
               chk(k == 0 ? "R4 pulse end" : "R5 pulse end", wake, 0);
            end

      // R6 ring during battery is ignored
      cfg(1, 1);
      main_ok = 0; tick(4);
      chk("R6 battery", st, 1);
      strobe(1);
      tick(2);
      go_main(hold, wakes, unm);
      chk("R6 holdoff wakes", wakes, 0);
      tick(1); chk("R6 no wake a", wake, 0);
      tick(1); chk("R6 no wake b", wake, 0);

      // R7 time match on battery is remembered
      main_ok = 0; tick(4);
      strobe(0);
      tick(5);
      go_main(hold, wakes, unm);
      chk("R7 holdoff wakes", wakes, 0);
      chk("R7 first ready cycle", wake, 0);
      tick(1); chk("R7 wake", wake, 1);
      tick(1); chk("R7 pulse end", wake, 0);

      // R8 R9 software off during holdoff discards pending event
      main_ok = 0; tick(4);
      main_ok = 1;
      for (int i = 0; i < 10 && st != 2'b10; i++) tick(1);
      chk("R8 holdoff entered", st, 2);
      strobe(0);
      strobe(2);
      chk("R9 off in holdoff", off, 1);
      tick(1); chk("R9 off end", off, 0);
      go_main(hold, wakes, unm);
      tick(1); chk("R8 no wake a", wake, 0);
      tick(1); chk("R8 no wake b", wake, 0);

      // R9 off in ready and on battery
      strobe(2);
      chk("R9 off ready", off, 1);
      tick(1); chk("R9 off one cycle", off, 0);
      main_ok = 0; tick(4);
      strobe(2);
      chk("R9 no off battery", off, 0);
      go_main(hold, wakes, unm);
      tick(1);

      // R10 enables survive system reset
      cfg(1, 1);
      sys_rst_n = 0; tick(2); sys_rst_n = 1; tick(1);
      strobe(0);
      chk("R10 time after sysrst", wake, 1);
      tick(1);
      strobe(1);
      chk("R10 ring after sysrst", wake, 1);
      tick(1);

      // R11 no power clears enables
      main_ok = 0; bat_ok = 0; tick(4);
      chk("R11 state", st, 0);
      bat_ok = 1; tick(4);
      go_main(hold, wakes, unm);
      chk("R11 holdoff after none", hold, H);
      tick(1);
      strobe(0);
      chk("R11 time cleared", wake, 0);
      tick(1);
      strobe(1);
      chk("R11 ring cleared", wake, 0);
      tick(1);
      cfg(1, 0);
      strobe(0);
      chk("R11 rewritten enable", wake, 1);
      tick(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule